// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block keeps the control state of one full-speed USB endpoint and picks the handshake for every transaction aimed at it. A serial engine upstream reports decoded tokens (OUT, IN, SETUP). For data it receives, it reports the data PID parity and whether the CRC checked out. For data the endpoint sent, it reports whether the host acknowledged it or the exchange was lost. The responder compares these against its per-direction force-NAK and force-STALL bits, its data toggles and the occupancy of the packet FIFO. It then answers ACK, NAK, STALL or stays silent. For an IN token it can instead start a data packet, and for an OUT or SETUP packet it tells the FIFO side whether to keep the data.

Software reaches the block through a small write port. There is one control byte per direction, a write-one-to-clear port on a sticky interrupt status byte, an enable mask, and an option byte. A control write that arrives while a transaction is running is parked and lands at the end of that transaction, so a transaction never sees its rules change half way. With the auto-NAK option on, every transaction that moves fresh data sets force-NAK in both directions, so software can inspect the data before the next packet is allowed.

Top module: `usb_ep_handshake`

## Requirements
- R1: When force-STALL is set in a direction, an IN token (IN direction) or a good OUT data packet (OUT direction) is answered with hs_code 3 (STALL), even if force-NAK is also set; force-NAK alone gives hs_code 2 (NAK).
- R2: A control write (wr_sel 0 for IN, 1 for OUT) made between a token and the end of its transaction does not change in_ctl/out_ctl until the transaction ends, and it governs the transaction after it. Writes made while idle apply at the next edge.
- R3: With option bit 0 (wr_sel 4) set, a transaction that moved data sets force-NAK (control bit 0) in both directions. This covers an IN the host acknowledged and an OUT or SETUP packet the endpoint kept.
- R4: An IN token with FIFO level 0 gets NAK, unless the short-packet bit (IN control bit 2) is set. In that case tx_go pulses and no handshake is given. With data present and no force bit set, tx_go pulses.
- R5: Control write bit 4 sets and bit 5 clears that direction's toggle, and set wins when both are written. The toggle is read back as control bit 3.
- R6: tx_odd carries the IN toggle. A host acknowledge of the IN packet flips the IN toggle, and an accepted OUT packet flips the OUT toggle.
- R7: An OUT packet whose PID parity differs from the OUT toggle is answered ACK with rx_keep low and the toggle unchanged. With ign_tog_mismatch high it is kept and the toggle flips.
- R8: An OUT packet is NAKed when the FIFO cannot take MAX_PKT more bytes. A packet with a bad CRC gets no handshake (hs_valid low) and sets the OUT error status bit.
- R9: Status bits, from bit 7 down to bit 0, are: IN ACK, OUT ACK, IN error, OUT error, IN NAK, OUT NAK, IN token seen, OUT token seen. Each stays set until a 1 is written to it through wr_sel 2.
- R10: irq is high exactly when some status bit and its enable bit (wr_sel 3) are both set. It follows the status and enable registers with no extra delay.
- R11: A good SETUP packet is always ACKed and kept, whatever the force bits. It sets both toggles to 1 and clears both force-STALL bits.
- R12: When an IN packet is sent but the host reports it lost, the IN error status bit is set and the IN toggle keeps its value.
- R13: After reset, all control, status, enable and option state is 0, and no output pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | One-cycle pulse: a token for this endpoint |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP |
| pkt_done | input | 1 | One-cycle pulse: received data packet ended |
| pkt_odd | input | 1 | Received data PID parity (1 = DATA1) |
| pkt_crc_ok | input | 1 | Received packet CRC was good |
| host_ack | input | 1 | Host acknowledged the sent IN packet |
| host_lost | input | 1 | Sent IN packet got no valid acknowledge |
| fifo_level | input | LW | Bytes held in the endpoint FIFO |
| ign_tog_mismatch | input | 1 | Accept packets whose toggle mismatches |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | 0 IN ctl, 1 OUT ctl, 2 status clear, 3 enable, 4 options |
| wr_data | input | 8 | Write data |
| hs_valid | output | 1 | Handshake to send this cycle |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| tx_go | output | 1 | Start sending an IN data packet |
| tx_odd | output | 1 | PID parity for that packet |
| rx_keep | output | 1 | Keep the OUT/SETUP data just received |
| in_ctl | output | 8 | IN control: bit0 force-NAK, bit1 force-STALL, bit2 short, bit3 toggle |
| out_ctl | output | 8 | OUT control: same layout, bit2 always 0 |
| int_stat | output | 8 | Sticky interrupt status |
| int_en | output | 8 | Interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the edge where a control write and a transaction overlap. A design that applied the write at once would let a freshly written STALL hit the packet already in flight, and one that lost the parked write would never stall the next packet. It replays stale OUT packets with the wrong parity, where a faulty design either drops the ACK, keeping the host retrying forever, or advances the toggle and silently loses the next packet. It also checks the priority between STALL and NAK, the empty-FIFO IN with and without the short-packet bit, and a SETUP landing on a stalled endpoint. A randomized run of OUT packets against a bench model then mixes FIFO levels, CRC failures and force bits.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {HS_NONE = 2'd0, HS_ACK = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3} hs_code_t;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_HOST, ST_WAIT_OUT, ST_WAIT_SETUP} txn_state_t;

  localparam logic [1:0] TK_OUT   = 2'd0;
  localparam logic [1:0] TK_IN    = 2'd1;
  localparam logic [1:0] TK_SETUP = 2'd2;

  // status byte bit positions
  localparam int SB_IN_ACK  = 7;
  localparam int SB_OUT_ACK = 6;
  localparam int SB_IN_ERR  = 5;
  localparam int SB_OUT_ERR = 4;
  localparam int SB_IN_NAK  = 3;
  localparam int SB_OUT_NAK = 2;
  localparam int SB_IN_TOK  = 1;
  localparam int SB_OUT_TOK = 0;

  // control byte bit positions
  localparam int CB_FNAK   = 0;
  localparam int CB_FSTALL = 1;
  localparam int CB_SHORT  = 2;
  localparam int CB_TOG    = 3;
  localparam int CB_TSET   = 4;
  localparam int CB_TCLR   = 5;

  // write port selectors
  localparam logic [2:0] SEL_IN  = 3'd0;
  localparam logic [2:0] SEL_OUT = 3'd1;
  localparam logic [2:0] SEL_CLR = 3'd2;
  localparam logic [2:0] SEL_EN  = 3'd3;
  localparam logic [2:0] SEL_OPT = 3'd4;
endpackage

// File: rtl/ep_dir_ctrl.sv
module ep_dir_ctrl
  import ep_hs_pkg::*;
#(
  parameter bit IS_IN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_data,
  input  logic             in_txn,
  input  logic             done,
  input  logic             tog_flip,
  input  logic             tog_force1,
  input  logic             clr_stall,
  input  logic             auto_fire,
  output logic             fnak_o,
  output logic             fstall_o,
  output logic             short_o,
  output logic             tog_o,
  output logic [REG_W-1:0] ctl_o
);
  logic             fnak_q, fstall_q, short_q, tog_q;
  logic             pend_v;
  logic [REG_W-1:0] pend_d;
  logic             apply, src_v;
  logic [REG_W-1:0] src;
  logic             fnak_n, fstall_n, short_n, tog_n;
  logic             unused_bits;

  // Control changes land only while idle or on the closing edge of a transaction
  assign apply = !in_txn || done;
  assign src_v = wr_hit || pend_v;
  assign src   = wr_hit ? wr_data : pend_d;
  assign unused_bits = ^{src[REG_W-1:CB_TCLR+1], src[CB_TOG], src[CB_SHORT]};

  always_comb begin
    // transaction effects first, then the software write, then auto-NAK
    tog_n    = tog_q ^ tog_flip;
    if (tog_force1) tog_n = 1'b1;
    fstall_n = clr_stall ? 1'b0 : fstall_q;
    fnak_n   = fnak_q;
    short_n  = short_q;
    if (src_v) begin
      fnak_n   = src[CB_FNAK];
      fstall_n = src[CB_FSTALL];
      short_n  = IS_IN ? src[CB_SHORT] : 1'b0;
      if (src[CB_TCLR]) tog_n = 1'b0;
      if (src[CB_TSET]) tog_n = 1'b1;
    end
    if (auto_fire) fnak_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fnak_q   <= 1'b0;
      fstall_q <= 1'b0;
      short_q  <= 1'b0;
      tog_q    <= 1'b0;
      pend_v   <= 1'b0;
      pend_d   <= '0;
    end else if (apply) begin
      fnak_q   <= fnak_n;
      fstall_q <= fstall_n;
      short_q  <= short_n;
      tog_q    <= tog_n;
      pend_v   <= 1'b0;
    end else if (wr_hit) begin
      pend_v   <= 1'b1;
      pend_d   <= wr_data;
    end
  end

  assign fnak_o   = fnak_q;
  assign fstall_o = fstall_q;
  assign short_o  = short_q;
  assign tog_o    = tog_q;
  assign ctl_o    = {{(REG_W-4){1'b0}}, tog_q, short_q, fstall_q, fnak_q};

  // R2: mid-transaction, the live control state holds still
  assert_defer_R2: assert property (@(posedge clk) disable iff (rst)
    (in_txn && !done) |=> ($stable(fnak_q) && $stable(fstall_q) && $stable(short_q) && $stable(tog_q)));

  // R3: auto-NAK leaves force-NAK set
  assert_auto_nak_R3: assert property (@(posedge clk) disable iff (rst)
    auto_fire |=> fnak_q);
endmodule

// File: rtl/ep_txn_fsm.sv
module ep_txn_fsm
  import ep_hs_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int MAX_PKT    = 16,
  parameter int LW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          pkt_done,
  input  logic          pkt_odd,
  input  logic          pkt_crc_ok,
  input  logic          host_ack,
  input  logic          host_lost,
  input  logic [LW-1:0] fifo_level,
  input  logic          ign_tog,
  input  logic          auto_nak,
  input  logic          in_fnak,
  input  logic          in_fstall,
  input  logic          in_short,
  input  logic          in_tog,
  input  logic          out_fnak,
  input  logic          out_fstall,
  input  logic          out_tog,
  output logic          in_txn,
  output logic          done,
  output logic          flip_in,
  output logic          flip_out,
  output logic          setup_hit,
  output logic          auto_fire,
  output logic [7:0]    ev,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          tx_go,
  output logic          tx_odd,
  output logic          rx_keep
);
  localparam int ROOM_LIMIT = FIFO_DEPTH - MAX_PKT;

  txn_state_t st_q, st_n;
  hs_code_t   resp;
  logic       resp_v, go, keep, tok_ok, has_room, fifo_empty;

  assign tok_ok     = tok_valid && (tok_kind != 2'd3);
  assign in_txn     = (st_q != ST_IDLE) || tok_ok;
  assign has_room   = fifo_level <= LW'(ROOM_LIMIT);
  assign fifo_empty = fifo_level == '0;

  always_comb begin
    st_n = st_q; done = 1'b0; resp_v = 1'b0; resp = HS_NONE; go = 1'b0; keep = 1'b0;
    flip_in = 1'b0; flip_out = 1'b0; setup_hit = 1'b0; auto_fire = 1'b0; ev = '0;
    unique case (st_q)
      ST_IDLE: if (tok_ok) begin
        if (tok_kind == TK_IN) begin
          ev[SB_IN_TOK] = 1'b1;
          if (in_fstall) begin
            resp_v = 1'b1; resp = HS_STALL; done = 1'b1;
          end else if (in_fnak || (fifo_empty && !in_short)) begin
            resp_v = 1'b1; resp = HS_NAK; done = 1'b1; ev[SB_IN_NAK] = 1'b1;
          end else begin
            go = 1'b1; st_n = ST_WAIT_HOST;
          end
        end else begin
          ev[SB_OUT_TOK] = 1'b1;
          st_n = (tok_kind == TK_SETUP) ? ST_WAIT_SETUP : ST_WAIT_OUT;
        end
      end
      ST_WAIT_HOST: if (host_ack) begin
        done = 1'b1; st_n = ST_IDLE; flip_in = 1'b1; ev[SB_IN_ACK] = 1'b1; auto_fire = auto_nak;
      end else if (host_lost) begin
        done = 1'b1; st_n = ST_IDLE; ev[SB_IN_ERR] = 1'b1;
      end
      ST_WAIT_OUT: if (pkt_done) begin
        done = 1'b1; st_n = ST_IDLE;
        if (!pkt_crc_ok) begin
          ev[SB_OUT_ERR] = 1'b1;
        end else if (out_fstall) begin
          resp_v = 1'b1; resp = HS_STALL;
        end else if (out_fnak || !has_room) begin
          resp_v = 1'b1; resp = HS_NAK; ev[SB_OUT_NAK] = 1'b1;
        end else begin
          resp_v = 1'b1; resp = HS_ACK; ev[SB_OUT_ACK] = 1'b1;
          if ((pkt_odd == out_tog) || ign_tog) begin
            keep = 1'b1; flip_out = 1'b1; auto_fire = auto_nak;
          end
        end
      end
      ST_WAIT_SETUP: if (pkt_done) begin
        done = 1'b1; st_n = ST_IDLE;
        if (!pkt_crc_ok) begin
          ev[SB_OUT_ERR] = 1'b1;
        end else begin
          resp_v = 1'b1; resp = HS_ACK; ev[SB_OUT_ACK] = 1'b1;
          keep = 1'b1; setup_hit = 1'b1; auto_fire = auto_nak;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      tx_go    <= 1'b0;
      tx_odd   <= 1'b0;
      rx_keep  <= 1'b0;
    end else begin
      st_q     <= st_n;
      hs_valid <= resp_v;
      hs_code  <= resp;
      tx_go    <= go;
      tx_odd   <= go ? in_tog : tx_odd;
      rx_keep  <= keep;
    end
  end

  // R1: STALL wins over NAK in both directions
  assert_in_stall_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && tok_valid && tok_kind == TK_IN && in_fstall) |=> (hs_valid && hs_code == HS_STALL));
  assert_out_stall_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT_OUT && pkt_done && pkt_crc_ok && out_fstall) |=> (hs_valid && hs_code == HS_STALL));
  // R7: kept data is always acknowledged
  assert_keep_ack_R7: assert property (@(posedge clk) disable iff (rst)
    rx_keep |-> (hs_valid && hs_code == HS_ACK));
  // R4: sending data and giving a handshake never coincide
  assert_go_no_hs_R4: assert property (@(posedge clk) disable iff (rst)
    tx_go |-> !hs_valid);
endmodule

// File: rtl/ep_int_status.sv
module ep_int_status
  import ep_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ev,
  input  logic             clr_hit,
  input  logic             en_hit,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] en_o,
  output logic             irq_o
);
  logic [REG_W-1:0] stat_q, en_q, stat_n, en_n;
  logic             irq_q;

  // new events win over a same-cycle clear
  assign stat_n = (stat_q & ~(clr_hit ? wr_data : '0)) | ev;
  assign en_n   = en_hit ? wr_data : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      en_q   <= en_n;
      irq_q  <= |(stat_n & en_n);
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  // R9: without a clear, no status bit ever drops
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import ep_hs_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int MAX_PKT    = 16,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          pkt_done,
  input  logic          pkt_odd,
  input  logic          pkt_crc_ok,
  input  logic          host_ack,
  input  logic          host_lost,
  input  logic [LW-1:0] fifo_level,
  input  logic          ign_tog_mismatch,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [7:0]    wr_data,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          tx_go,
  output logic          tx_odd,
  output logic          rx_keep,
  output logic [7:0]    in_ctl,
  output logic [7:0]    out_ctl,
  output logic [7:0]    int_stat,
  output logic [7:0]    int_en,
  output logic          irq
);
  localparam int NDIR = 2;   // index 0 = OUT, index 1 = IN

  logic [NDIR-1:0] fnak, fstall, shrt, tog, flip;
  logic [REG_W-1:0] ctl [NDIR];
  logic             in_txn, done, flip_in, flip_out, setup_hit, auto_fire;
  logic [7:0]       ev;
  logic             auto_nak_q;

  assign flip = {flip_in, flip_out};

  always_ff @(posedge clk) begin
    if (rst)                          auto_nak_q <= 1'b0;
    else if (wr_en && wr_sel == SEL_OPT) auto_nak_q <= wr_data[0];
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    ep_dir_ctrl #(.IS_IN(g == 1)) u_dir (
      .clk       (clk),
      .rst       (rst),
      .wr_hit    (wr_en && (wr_sel == ((g == 1) ? SEL_IN : SEL_OUT))),
      .wr_data   (wr_data),
      .in_txn    (in_txn),
      .done      (done),
      .tog_flip  (flip[g]),
      .tog_force1(setup_hit),
      .clr_stall (setup_hit),
      .auto_fire (auto_fire),
      .fnak_o    (fnak[g]),
      .fstall_o  (fstall[g]),
      .short_o   (shrt[g]),
      .tog_o     (tog[g]),
      .ctl_o     (ctl[g])
    );
  end

  ep_txn_fsm #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_PKT(MAX_PKT), .LW(LW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .pkt_done  (pkt_done),
    .pkt_odd   (pkt_odd),
    .pkt_crc_ok(pkt_crc_ok),
    .host_ack  (host_ack),
    .host_lost (host_lost),
    .fifo_level(fifo_level),
    .ign_tog   (ign_tog_mismatch),
    .auto_nak  (auto_nak_q),
    .in_fnak   (fnak[1]),
    .in_fstall (fstall[1]),
    .in_short  (shrt[1]),
    .in_tog    (tog[1]),
    .out_fnak  (fnak[0]),
    .out_fstall(fstall[0]),
    .out_tog   (tog[0]),
    .in_txn    (in_txn),
    .done      (done),
    .flip_in   (flip_in),
    .flip_out  (flip_out),
    .setup_hit (setup_hit),
    .auto_fire (auto_fire),
    .ev        (ev),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code),
    .tx_go     (tx_go),
    .tx_odd    (tx_odd),
    .rx_keep   (rx_keep)
  );

  ep_int_status u_stat (
    .clk    (clk),
    .rst    (rst),
    .ev     (ev),
    .clr_hit(wr_en && wr_sel == SEL_CLR),
    .en_hit (wr_en && wr_sel == SEL_EN),
    .wr_data(wr_data),
    .stat_o (int_stat),
    .en_o   (int_en),
    .irq_o  (irq)
  );

  assign in_ctl  = ctl[1];
  assign out_ctl = ctl[0];

  // R6: toggle of the OUT side never moves by an IN completion alone
  assert_in_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (flip_in && !setup_hit && !(wr_en && wr_sel == SEL_OUT)) |=> $stable(out_ctl[CB_TOG]));
endmodule

// File: tb/usb_ep_handshake_tb.sv
`timescale 1ns/1ps
module usb_ep_handshake_tb;
  localparam int FD = 64;
  localparam int MP = 16;
  localparam int LW = $clog2(FD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_valid = 0, pkt_done = 0, pkt_odd = 0, pkt_crc_ok = 0, host_ack = 0, host_lost = 0;
  logic [1:0] tok_kind = 0;
  logic [LW-1:0] fifo_level = 0;
  logic ign = 0, wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic hs_valid, tx_go, tx_odd, rx_keep, irq;
  logic [1:0] hs_code;
  logic [7:0] in_ctl, out_ctl, int_stat, int_en;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  usb_ep_handshake #(.FIFO_DEPTH(FD), .MAX_PKT(MP)) u_dut (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind), .pkt_done(pkt_done),
    .pkt_odd(pkt_odd), .pkt_crc_ok(pkt_crc_ok), .host_ack(host_ack), .host_lost(host_lost),
    .fifo_level(fifo_level), .ign_tog_mismatch(ign), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .hs_valid(hs_valid), .hs_code(hs_code), .tx_go(tx_go), .tx_odd(tx_odd),
    .rx_keep(rx_keep), .in_ctl(in_ctl), .out_ctl(out_ctl), .int_stat(int_stat), .int_en(int_en),
    .irq(irq)
  );

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick; wr_en = 0;
  endtask
  task automatic tok(input logic [1:0] k);
    tok_valid = 1; tok_kind = k; tick; tok_valid = 0;
  endtask
  task automatic pkt(input logic o, input logic c);
    pkt_done = 1; pkt_odd = o; pkt_crc_ok = c; tick; pkt_done = 0;
  endtask
  task automatic host(input logic a);
    if (a) host_ack = 1; else host_lost = 1;
    tick; host_ack = 0; host_lost = 0;
  endtask

  // bench model of one OUT transaction: {hs_valid, hs_code, rx_keep, new toggle}
  function automatic logic [4:0] exp_out(input logic fn, input logic fs, input int lvl,
                                         input logic o, input logic c, input logic ig, input logic t);
    if (!c)                     return {1'b0, 2'd0, 1'b0, t};
    if (fs)                     return {1'b1, 2'd3, 1'b0, t};
    if (fn || lvl > FD - MP)    return {1'b1, 2'd2, 1'b0, t};
    if (o != t && !ig)          return {1'b1, 2'd1, 1'b0, t};
    return {1'b1, 2'd1, 1'b1, ~t};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic m_tog;
    void'($urandom(32'h5eed_1234));
    repeat (3) tick;
    rst = 0;
    tick;
    // R13 reset state
    chk("R13 in_ctl", in_ctl, 0);
    chk("R13 out_ctl", out_ctl, 0);
    chk("R13 int_stat", int_stat, 0);
    chk("R13 irq", irq, 0);
    chk("R13 hs_valid", hs_valid, 0);

    // R4 / R9: IN with empty FIFO gets NAK
    tok(2'd1);
    chk("R4 empty IN NAK valid", hs_valid, 1);
    chk("R4 empty IN NAK code", hs_code, 2);
    chk("R9 status IN tok+NAK", int_stat, 8'h0A);
    wr(3'd2, 8'h02);
    chk("R9 partial clear", int_stat, 8'h08);
    wr(3'd2, 8'hFF);
    chk("R9 full clear", int_stat, 0);

    // R4 short packet, R6 toggle flip on host ack
    wr(3'd0, 8'h04);
    tok(2'd1);
    chk("R4 short IN tx_go", tx_go, 1);
    chk("R4 short IN no hs", hs_valid, 0);
    chk("R6 tx_odd first", tx_odd, 0);
    host(1'b1);
    chk("R6 IN toggle flipped", in_ctl[3], 1);
    chk("R9 IN ACK bit", int_stat[7], 1);

    // R12 host lost: error, no flip
    wr(3'd0, 8'h00);
    fifo_level = 5;
    tok(2'd1);
    chk("R6 tx_odd second", tx_odd, 1);
    host(1'b0);
    chk("R12 IN toggle kept", in_ctl[3], 1);
    chk("R12 IN error bit", int_stat[5], 1);
    fifo_level = 0;

    // R5 strobes
    wr(3'd0, 8'h20);
    chk("R5 clear strobe", in_ctl[3], 0);
    wr(3'd0, 8'h10);
    chk("R5 set strobe", in_ctl[3], 1);
    wr(3'd0, 8'h30);
    chk("R5 set wins", in_ctl[3], 1);
    wr(3'd0, 8'h20);

    // R1 STALL over NAK
    wr(3'd0, 8'h03);
    tok(2'd1);
    chk("R1 IN stall", hs_code, 3);
    wr(3'd1, 8'h03);
    tok(2'd0); pkt(1'b0, 1'b1);
    chk("R1 OUT stall", hs_code, 3);
    wr(3'd1, 8'h01);
    tok(2'd0); pkt(1'b0, 1'b1);
    chk("R1 OUT nak only", hs_code, 2);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    // R2 deferred write
    tok(2'd0);
    wr(3'd1, 8'h02);
    chk("R2 write held", out_ctl[1], 0);
    pkt(1'b0, 1'b1);
    chk("R2 old rule applies", hs_code, 1);
    chk("R2 write landed", out_ctl, 8'h0A);
    tok(2'd0); pkt(1'b1, 1'b1);
    chk("R2 next txn stalls", hs_code, 3);
    wr(3'd1, 8'h00);

    // R7 toggle mismatch (OUT toggle is 1)
    tok(2'd0); pkt(1'b0, 1'b1);
    chk("R7 mismatch ACK", hs_code, 1);
    chk("R7 mismatch dropped", rx_keep, 0);
    chk("R7 toggle held", out_ctl[3], 1);
    ign = 1;
    tok(2'd0); pkt(1'b0, 1'b1);
    chk("R7 ignore keeps", rx_keep, 1);
    chk("R7 ignore flips", out_ctl[3], 0);
    ign = 0;

    // R8 no room and bad CRC
    wr(3'd2, 8'hFF);
    fifo_level = 60;
    tok(2'd0); pkt(1'b0, 1'b1);
    chk("R8 no room NAK", hs_code, 2);
    chk("R8 OUT NAK bit", int_stat[2], 1);
    fifo_level = 0;
    tok(2'd0); pkt(1'b0, 1'b0);
    chk("R8 bad crc silent", hs_valid, 0);
    chk("R8 OUT err bit", int_stat[4], 1);

    // R10 interrupt mask
    chk("R10 masked", irq, 0);
    wr(3'd3, 8'h10);
    chk("R10 enabled", irq, 1);
    wr(3'd2, 8'h10);
    chk("R10 cleared", irq, 0);

    // R11 SETUP overrides stall
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h02);
    tok(2'd2); pkt(1'b0, 1'b1);
    chk("R11 setup ACK", hs_code, 1);
    chk("R11 setup kept", rx_keep, 1);
    chk("R11 in_ctl", in_ctl, 8'h08);
    chk("R11 out_ctl", out_ctl, 8'h08);

    // R3 auto NAK (OUT toggle is 1)
    wr(3'd4, 8'h01);
    tok(2'd0); pkt(1'b1, 1'b1);
    chk("R3 ACK", hs_code, 1);
    chk("R3 OUT fnak set", out_ctl[0], 1);
    chk("R3 IN fnak set", in_ctl[0], 1);
    tok(2'd0); pkt(1'b0, 1'b1);
    chk("R3 next NAK", hs_code, 2);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h20);

    // randomized OUT traffic against the model (R1 R7 R8)
    m_tog = 0;
    for (int i = 0; i < 60; i++) begin
      logic fn, fs, o, c;
      int lvl;
      logic [4:0] e;
      fs = ($urandom % 8) == 0;
      fn = ($urandom % 4) == 0;
      o  = 1'($urandom % 2);
      c  = ($urandom % 6) != 0;
      lvl = $urandom % (FD + 1);
      ign = ($urandom % 5) == 0;
      wr(3'd1, {6'b0, fs, fn});
      fifo_level = LW'(lvl);
      e = exp_out(fn, fs, lvl, o, c, ign, m_tog);
      tok(2'd0); pkt(o, c);
      chk("R8 rand hs_valid", hs_valid, e[4]);
      if (e[4]) chk("R1 rand hs_code", hs_code, e[3:2]);
      chk("R7 rand rx_keep", rx_keep, e[1]);
      chk("R7 rand toggle", out_ctl[3], e[0]);
      m_tog = e[0];
      ign = 0;
      fifo_level = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule